// File: doc/BRIEF.md
# SPI Bit-Clock Rate Selector

This block turns a fixed 200 MHz reference into the single-cycle enable that paces a serial flash interface's bit clock. Software selects the rate with two register writes. A 4-bit rate code in the enable register picks one of a few fixed divide ratios. One code instead hands the choice to a 6-bit divisor held in the speed register. A separate high-speed permission bit must also be set before the fastest ratio (divide by 2) may be used.

The decoded ratio is only loaded into the running divider while no command is in progress, that is while the chip-select qualifier `cs_active` is low. A write made during a command therefore cannot shorten or stretch a bit period halfway through a transfer. The divider runs only while `cs_active` is high and emits `bit_tick` once every ratio reference cycles. The serial shifter consumes that tick. The active ratio is also presented on `rate_ratio`.

Top module: `spi_rate_sel`

## Requirements
- R1: After synchronous reset, `rate_ratio` is 250 and `bit_tick` is 0.
- R2: A write to address 0x20 sets the rate code from data bits 23:20. Codes 0, 1, 2 and 3 give ratios 3, 6, 9 and 12.
- R3: Code 4 gives ratio 2 only when bit 0 of the same enable-register write is 1. With that bit 0, code 4 gives ratio 250.
- R4: Code 7 takes its ratio from the 6-bit divisor written to data bits 13:8 at address 0x6C. Divisor values 0 and 1 give ratio 2.
- R5: Codes 5, 6 and 8 to 15 give ratio 250.
- R6: While `cs_active` is high, the first `bit_tick` comes N cycles after `cs_active` is first sampled high, where N is the active ratio. After that, `bit_tick` repeats every N cycles, and each pulse lasts one cycle.
- R7: While `cs_active` is low, `bit_tick` stays 0, and the next command restarts the count from zero.
- R8: `rate_ratio` changes only in a cycle following one in which `cs_active` was low. A register write made during a command takes effect once `cs_active` falls.
- R9: Writes to other addresses leave the rate unchanged. Data bits outside the fields (outside 23:20 and 0 at 0x20, outside 13:8 at 0x6C) also leave the rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| cs_active | input | 1 | High while a command is in progress |
| bit_tick | output | 1 | One-cycle bit-clock enable |
| rate_ratio | output | 8 | Divide ratio currently in force |

## Verification
The decode is swept over all sixteen codes with the high-speed bit both clear and set. Noise is written into the bits outside the fields, which separates the field positions from the fallback and permission rules. The divisor is swept over all 64 values under code 7, which shows the floor of 2 and exact pass-through above it. Tick intervals are measured for the smallest, middle and largest ratios. These measurements catch off-by-one errors in the counter wrap and in the first-tick latency. Writes made during a command, and writes to a foreign address, show that the rate only moves at command boundaries and only through its own fields.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned RATIO_W    = 8;
  // Fixed ratios against a 200 MHz reference
  localparam logic [RATIO_W-1:0] RATIO_FAST  = 8'd2;
  localparam logic [RATIO_W-1:0] RATIO_SLOW  = 8'd250;
  localparam logic [RATIO_W-1:0] RATIO_STEP  = 8'd3;
  localparam logic [CODE_W-1:0]  CODE_TURBO  = 4'd4;
  localparam logic [CODE_W-1:0]  CODE_PROG   = 4'd7;
endpackage

// File: rtl/spi_rate_regs.sv
module spi_rate_regs
  import spi_rate_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned CODE_LSB = 20,
  parameter int unsigned DIV_LSB  = 8,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] SPD_OFS = 8'h6C,
  parameter logic [CODE_W-1:0] RST_CODE = 4'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_q,
  output logic              turbo_q,
  output logic [DIV_W-1:0]  div_q
);
  logic hit_ena, hit_spd;
  logic unused_data;

  assign hit_ena = wr_en && (wr_addr == ENA_OFS);
  assign hit_spd = wr_en && (wr_addr == SPD_OFS);
  assign unused_data = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= RST_CODE;
      turbo_q <= 1'b0;
      div_q   <= '0;
    end else begin
      if (hit_ena) begin
        code_q  <= wr_data[CODE_LSB +: CODE_W];
        turbo_q <= wr_data[0];
      end
      if (hit_spd) begin
        div_q <= wr_data[DIV_LSB +: DIV_W];
      end
    end
  end

  // R9: writes elsewhere leave every field alone
  a_r9_foreign_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ENA_OFS && wr_addr != SPD_OFS)
      |=> ($stable(code_q) && $stable(turbo_q) && $stable(div_q)));
endmodule

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
  import spi_rate_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic [CODE_W-1:0]  code,
  input  logic               turbo,
  input  logic [DIV_W-1:0]   div,
  output logic [RATIO_W-1:0] ratio
);
  localparam logic [RATIO_W-1:0] DIV_FLOOR = RATIO_FAST;

  logic [RATIO_W-1:0] div_ext;
  assign div_ext = RATIO_W'(div);

  always_comb begin
    ratio = RATIO_SLOW;
    if (code < CODE_TURBO) begin
      ratio = RATIO_STEP * (RATIO_W'(code) + RATIO_W'(1));
    end else if (code == CODE_TURBO) begin
      ratio = turbo ? RATIO_FAST : RATIO_SLOW;
    end else if (code == CODE_PROG) begin
      ratio = (div_ext < DIV_FLOOR) ? DIV_FLOOR : div_ext;
    end
  end
endmodule

// File: rtl/spi_rate_divider.sv
module spi_rate_divider
  import spi_rate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_active,
  input  logic [RATIO_W-1:0] ratio_next,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               bit_tick
);
  logic [RATIO_W-1:0] cnt;
  logic               wrap;

  assign wrap = (cnt == ratio_q - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q  <= RATIO_SLOW;
      cnt      <= '0;
      bit_tick <= 1'b0;
    end else if (!cs_active) begin
      ratio_q  <= ratio_next;
      cnt      <= '0;
      bit_tick <= 1'b0;
    end else begin
      cnt      <= wrap ? '0 : cnt + RATIO_W'(1);
      bit_tick <= wrap;
    end
  end

  // R7: idle means no tick
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !bit_tick);
  // R8: ratio frozen during a command
  a_r8_hold_in_cmd: assert property (@(posedge clk) disable iff (rst)
    cs_active |=> $stable(ratio_q));
  // R6: ticks are single-cycle pulses
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
  // R4: ratio never drops below two
  a_r4_floor_two: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= RATIO_FAST);
endmodule

// File: rtl/spi_rate_sel.sv
module spi_rate_sel
  import spi_rate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_active,
  output logic              bit_tick,
  output logic [7:0]        rate_ratio
);
  logic [CODE_W-1:0]  code_q;
  logic               turbo_q;
  logic [DIV_W-1:0]   div_q;
  logic [RATIO_W-1:0] ratio_next;

  spi_rate_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .code_q  (code_q),
    .turbo_q (turbo_q),
    .div_q   (div_q)
  );

  spi_rate_decode #(.DIV_W(DIV_W)) u_dec (
    .code  (code_q),
    .turbo (turbo_q),
    .div   (div_q),
    .ratio (ratio_next)
  );

  spi_rate_divider u_div (
    .clk        (clk),
    .rst        (rst),
    .cs_active  (cs_active),
    .ratio_next (ratio_next),
    .ratio_q    (rate_ratio),
    .bit_tick   (bit_tick)
  );
endmodule

// File: tb/tb_spi_rate_sel.sv
module tb_spi_rate_sel;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        cs_active;
  logic        bit_tick;
  logic [7:0]  rate_ratio;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_rate_sel dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cs_active(cs_active),
    .bit_tick(bit_tick), .rate_ratio(rate_ratio)
  );

  function automatic int exp_ratio(int code, int turbo, int dv);
    if (code < 4) return 3 * (code + 1);
    if (code == 4) return turbo ? 2 : 250;
    if (code == 7) return (dv < 2) ? 2 : dv;
    return 250;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Measure first-tick latency and one interval, then go idle
  task automatic measure(string req, int n);
    int c1 = 0;
    int c2 = 0;
    @(negedge clk);
    cs_active = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); c1++;
      if (bit_tick) break;
    end
    chk({req, " first tick"}, c1, n);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); c2++;
      if (bit_tick) break;
    end
    chk({req, " interval"}, c2, n);
    cs_active = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R7 idle tick", int'(bit_tick), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cs_active = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ratio", int'(rate_ratio), 250);
    chk("R1 reset tick", int'(bit_tick), 0);

    // R2/R3/R5/R9: all codes, both turbo values, noise outside fields
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 16; c++) begin
        wr(8'h20, 32'hF00F_FFFE & ~32'h0000_0001 | (32'(c) << 20) | 32'(t) | 32'h0F00_0000);
        @(negedge clk);
        chk((c < 4) ? "R2 code" : (c == 4) ? "R3 turbo" : (c == 7) ? "R4 prog" : "R5 fallback",
            int'(rate_ratio), exp_ratio(c, t, 0));
      end
    end

    // R4: divisor sweep under code 7
    wr(8'h20, 32'h0070_0000);
    for (int d = 0; d < 64; d++) begin
      wr(8'h6C, 32'hFFFF_C0FF & 32'hFFFF_FFFF | (32'(d) << 8));
      @(negedge clk);
      chk("R4 divisor", int'(rate_ratio), exp_ratio(7, 0, d));
    end

    // R6: tick timing across ratios
    wr(8'h6C, 32'h0000_0000); @(negedge clk);
    measure("R6 ratio2", 2);
    wr(8'h6C, 32'h0000_3F00); @(negedge clk);
    measure("R6 ratio63", 63);
    wr(8'h20, 32'h0000_0000); @(negedge clk);
    measure("R6 ratio3", 3);
    wr(8'h20, 32'h0030_0000); @(negedge clk);
    measure("R6 ratio12", 12);
    wr(8'h20, 32'h0050_0000); @(negedge clk);
    measure("R6 ratio250", 250);
    measure("R7 restart", 250);

    // R9: foreign address ignored
    wr(8'h21, 32'h0000_0000); @(negedge clk);
    chk("R9 foreign addr", int'(rate_ratio), 250);
    wr(8'h6D, 32'hFFFF_FFFF); @(negedge clk);
    chk("R9 foreign addr 2", int'(rate_ratio), 250);

    // R8: write during a command waits for idle
    wr(8'h20, 32'h0000_0000); @(negedge clk);
    chk("R8 pre", int'(rate_ratio), 3);
    cs_active = 1'b1;
    wr(8'h20, 32'h0010_0000);
    repeat (3) @(negedge clk);
    chk("R8 held in command", int'(rate_ratio), 3);
    cs_active = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 applied at idle", int'(rate_ratio), 6);
    measure("R8 new rate", 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule